// File: doc/BRIEF.md
# Instruction Prefetch Queue with Bus-Width Dependent Depth

This block sits between the memory port of a bus interface unit and the instruction decoder. It fetches code bytes ahead of execution, keeps them in a small ring, and hands the oldest one to the decoder each cycle. One parameter selects a two-byte or a one-byte external data path. That choice sets both how many bytes the queue can hold and how much room must be free before the next fetch starts.

A flush input models a jump. In one cycle it empties the queue and loads a new fetch address. A fetch already in flight when the flush arrives still completes on the memory port, but its data is discarded. On the two-byte path, a fetch from an odd address brings in only the upper byte, so every later fetch is word aligned. Bytes already held in the queue are never fetched again. A later memory write to those addresses therefore does not change what the decoder receives, and this makes the handling of self-modifying code predictable.

Top module: `pfq_top`

## Requirements
- R1: With BUS_BYTES=2 the queue holds at most 6 bytes. After a flush to an even address A with the decoder stalled, exactly three fetches are made, at A, A+2 and A+4, and then no more.
- R2: With BUS_BYTES=1 the queue holds at most 4 bytes and every fetch returns one byte. After a flush to A with the decoder stalled, the fetches are A, A+1, A+2 and A+3.
- R3: With BUS_BYTES=2 a new fetch is issued only when at least 2 bytes of the queue are free. With exactly 1 byte free, no fetch is issued.
- R4: With BUS_BYTES=1 a new fetch is issued as soon as at least 1 byte of the queue is free.
- R5: With BUS_BYTES=2, mem_rdata[7:0] carries the byte at the even address and mem_rdata[15:8] the byte at the odd address. A fetch from an odd address keeps only the mem_rdata[15:8] byte, and the next fetch goes to the following even address. A fetch from an even address keeps both bytes, lower address first.
- R6: A flush empties the queue, so dec_valid is low in the cycle after it. The next fetch request is made to flush_addr.
- R7: mem_req, once raised, stays high with mem_addr unchanged until mem_ack is sampled high. It is low in the cycle after that ack. Only one fetch is outstanding at a time.
- R8: Data acknowledged for a fetch that was outstanding when a flush arrived is discarded. This also applies when the ack comes in the flush cycle itself.
- R9: dec_valid is high whenever the queue is not empty, and dec_byte is then its oldest byte. A byte is consumed on a cycle with dec_valid and dec_ready both high, at most one per cycle. Bytes are delivered in ascending address order from the flush address.
- R10: A memory write to an address whose byte is already in the queue does not change the byte delivered for that address.
- R11: While rst_n is low, mem_req and dec_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Jump: empty the queue and restart fetching at flush_addr |
| flush_addr | input | ADDR_W | New fetch address, taken while flush is high |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the requested fetch |
| mem_ack | input | 1 | Fetch data valid on mem_rdata; completes the request |
| mem_rdata | input | 8*BUS_BYTES | Fetched data; lower byte lane holds the even address |
| dec_valid | output | 1 | A code byte is available |
| dec_byte | output | 8 | Oldest code byte in the queue |
| dec_ready | input | 1 | Decoder takes dec_byte this cycle |

## Verification
- **Fetch request:** mem_req rises one clock edge after room appears. The bench therefore judges refill behaviour only after several idle cycles, by comparing the list of acknowledged fetch addresses against the addresses the requirements predict.
- **Queue entry and flush:** returned bytes enter the queue at the edge where the ack is sampled, and dec_valid follows from the registered count in the same cycle. A flush clears dec_valid at its own edge, so the bench samples dec_valid a quarter period after that edge.
- **Delivered bytes:** the bench compares every byte taken by the decoder, at mid-cycle, against a scoreboard queue. The flush task fills that queue from the memory model at the moment of the flush, which is also how late memory writes and stale acks are shown to have no effect.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef logic [7:0] byte_t;
    typedef logic [1:0] push_cnt_t;

    // queue capacity in bytes for a given external data path width
    function automatic int queue_depth(input int bus_bytes);
        return (bus_bytes == 2) ? 6 : 4;
    endfunction

    // free bytes needed before a new fetch may start
    function automatic int refill_room(input int bus_bytes);
        return (bus_bytes == 2) ? 2 : 1;
    endfunction

endpackage

// File: rtl/pfq_store.sv
module pfq_store
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  push_cnt_t        push_n,
    input  byte_t            push_b0,
    input  byte_t            push_b1,
    input  logic             pop,
    output byte_t            head,
    output logic [CNT_W-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ring_t;

    ring_t r_q, r_d;
    byte_t dat_q [DEPTH];
    byte_t dat_d [DEPTH];
    logic [PTR_W-1:0] wp_d;

    function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d   = r_q;
        dat_d = dat_q;
        wp_d  = r_q.wr;
        if (clr) begin
            r_d = '0;
        end else begin
            if (push_n != 2'd0) begin
                dat_d[wp_d] = push_b0;
                wp_d        = ring_next(wp_d);
            end
            if (push_n == 2'd2) begin
                dat_d[wp_d] = push_b1;
                wp_d        = ring_next(wp_d);
            end
            r_d.wr = wp_d;
            if (pop) begin
                r_d.rd = ring_next(r_q.rd);
            end
            r_d.cnt = r_q.cnt + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                dat_q[i] <= '0;
            end
        end else begin
            r_q   <= r_d;
            dat_q <= dat_d;
        end
    end

    assign head  = dat_q[r_q.rd];
    assign count = r_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (int'(r_q.cnt) + int'(push_n) - int'(pop)) <= DEPTH); // R1
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> r_q.cnt != '0); // R9
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> r_q.cnt == '0); // R6

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter int BUS_BYTES = 2,
    parameter int ADDR_W    = 20,
    parameter int CNT_W     = 3,
    parameter int ROOM      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [ADDR_W-1:0]      flush_addr,
    input  logic [CNT_W-1:0]       free,
    input  logic                   mem_ack,
    input  logic [8*BUS_BYTES-1:0] mem_rdata,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr,
    output push_cnt_t              push_n,
    output byte_t                  push_b0,
    output byte_t                  push_b1
);

    localparam logic [CNT_W-1:0] ROOM_C = CNT_W'(ROOM);

    typedef struct packed {
        logic              req;
        logic              drop;
        logic              two;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] fp;
    } fch_t;

    fch_t  f_q, f_d;
    byte_t lane_lo, lane_hi;
    logic  pair_ok;

    generate
        if (BUS_BYTES == 2) begin : g_wide
            assign lane_lo = mem_rdata[7:0];
            assign lane_hi = mem_rdata[15:8];
            assign pair_ok = ~f_q.fp[0];
        end else begin : g_narrow
            assign lane_lo = mem_rdata[7:0];
            assign lane_hi = mem_rdata[7:0];
            assign pair_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        f_d     = f_q;
        push_n  = 2'd0;
        push_b0 = '0;
        push_b1 = '0;
        if (f_q.req && mem_ack) begin
            f_d.req  = 1'b0;
            f_d.drop = 1'b0;
            if (!f_q.drop && !flush) begin
                if (f_q.two) begin
                    push_n  = 2'd2;
                    push_b0 = lane_lo;
                    push_b1 = lane_hi;
                end else begin
                    push_n  = 2'd1;
                    push_b0 = lane_hi;
                end
            end
        end else if (f_q.req && flush) begin
            f_d.drop = 1'b1;
        end
        if (flush) begin
            f_d.fp = flush_addr;
        end else if (!f_q.req && free >= ROOM_C) begin
            f_d.req  = 1'b1;
            f_d.addr = f_q.fp;
            f_d.two  = pair_ok;
            f_d.fp   = f_q.fp + (pair_ok ? ADDR_W'(2) : ADDR_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mem_req  = f_q.req;
    assign mem_addr = f_q.addr;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R7
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req); // R7
    AST_REFILL_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(free) >= ROOM_C); // R3
    AST_ODD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        push_n == 2'd2 |-> !mem_addr[0]); // R5
    AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_req && flush && !mem_ack) && mem_ack |-> push_n == 2'd0); // R8

endmodule

// File: rtl/pfq_top.sv
module pfq_top
    import pfq_pkg::*;
#(
    parameter int BUS_BYTES = 2,
    parameter int ADDR_W    = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [ADDR_W-1:0]      flush_addr,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_ack,
    input  logic [8*BUS_BYTES-1:0] mem_rdata,
    output logic                   dec_valid,
    output logic [7:0]             dec_byte,
    input  logic                   dec_ready
);

    localparam int DEPTH = queue_depth(BUS_BYTES);
    localparam int ROOM  = refill_room(BUS_BYTES);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free;
    push_cnt_t        push_n;
    byte_t            push_b0, push_b1;
    logic             pop;

    assign dec_valid = (count != '0);
    assign pop       = dec_valid & dec_ready;
    assign free      = CNT_W'(DEPTH) - count;

    pfq_fetch #(
        .BUS_BYTES (BUS_BYTES),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .ROOM      (ROOM)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_addr (flush_addr),
        .free       (free),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .push_n     (push_n),
        .push_b0    (push_b0),
        .push_b1    (push_b1)
    );

    pfq_store #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flush),
        .push_n  (push_n),
        .push_b0 (push_b0),
        .push_b1 (push_b1),
        .pop     (pop),
        .head    (dec_byte),
        .count   (count)
    );

    AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH); // R1
    AST_FLUSH_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dec_valid); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !mem_req && !dec_valid); // R11

endmodule

// File: tb/sim_pfq_top.sv
module sim_pfq_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush;
    logic [19:0] faddr;
    logic        ready;
    logic        req [2];
    logic [19:0] maddr [2];
    logic        ack [2];
    logic [15:0] rdat0;
    logic [7:0]  rdat1;
    logic        vld [2];
    logic [7:0]  dbyte [2];

    logic [7:0]  mem [256];
    int          lat;
    int          wcnt [2];
    logic [19:0] log0 [$];
    logic [19:0] log1 [$];
    logic [7:0]  exp0 [$];
    logic [7:0]  exp1 [$];
    int          total = 0;
    int          bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pfq_top #(.BUS_BYTES(2), .ADDR_W(20)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(faddr),
        .mem_req(req[0]), .mem_addr(maddr[0]), .mem_ack(ack[0]), .mem_rdata(rdat0),
        .dec_valid(vld[0]), .dec_byte(dbyte[0]), .dec_ready(ready)
    );

    pfq_top #(.BUS_BYTES(1), .ADDR_W(20)) u1 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(faddr),
        .mem_req(req[1]), .mem_addr(maddr[1]), .mem_ack(ack[1]), .mem_rdata(rdat1),
        .dec_valid(vld[1]), .dec_byte(dbyte[1]), .dec_ready(ready)
    );

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #(CLK_P/4);
        end
    endtask

    // driver: the flush and the scoreboard fill
    task automatic do_flush(input logic [19:0] a);
        flush = 1'b1;
        faddr = a;
        exp0.delete();
        exp1.delete();
        for (int k = 0; k < 64; k++) begin
            exp0.push_back(mem[8'(a + 20'(k))]);
            exp1.push_back(mem[8'(a + 20'(k))]);
        end
        tick(1);
        flush = 1'b0;
    endtask

    // memory model: ack after lat negedges, data by R5 lane order
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                ack[i]  = 1'b0;
                wcnt[i] = 0;
            end else begin
                if (ack[i]) begin
                    total++;
                    if (req[i] !== 1'b0) begin
                        bad++;
                        $display("FAIL R7 inst%0d req after ack actual=%b expected=0", i, req[i]);
                    end
                end
                if (req[i] && !ack[i]) begin
                    if (wcnt[i] >= lat) begin
                        ack[i] = 1'b1;
                        if (i == 0) begin
                            rdat0 = {mem[{maddr[0][7:1], 1'b1}], mem[{maddr[0][7:1], 1'b0}]};
                            log0.push_back(maddr[0]);
                        end else begin
                            rdat1 = mem[maddr[1][7:0]];
                            log1.push_back(maddr[1]);
                        end
                    end else begin
                        wcnt[i]++;
                    end
                end else begin
                    ack[i]  = 1'b0;
                    wcnt[i] = 0;
                end
            end
        end
    end

    // monitor: every consumed byte against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ready) begin
            if (vld[0]) begin
                total++;
                if (exp0.size() == 0) begin
                    bad++;
                    $display("FAIL R9 inst0 unexpected byte actual=%0h expected=none", dbyte[0]);
                end else begin
                    logic [7:0] e0;
                    e0 = exp0.pop_front();
                    if (dbyte[0] !== e0) begin
                        bad++;
                        $display("FAIL R9 R10 R8 inst0 byte actual=%0h expected=%0h", dbyte[0], e0);
                    end
                end
            end
            if (vld[1]) begin
                total++;
                if (exp1.size() == 0) begin
                    bad++;
                    $display("FAIL R9 inst1 unexpected byte actual=%0h expected=none", dbyte[1]);
                end else begin
                    logic [7:0] e1;
                    e1 = exp1.pop_front();
                    if (dbyte[1] !== e1) begin
                        bad++;
                        $display("FAIL R9 R10 R8 inst1 byte actual=%0h expected=%0h", dbyte[1], e1);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int b0;
        int b1;
        flush = 1'b0;
        faddr = '0;
        ready = 1'b0;
        lat   = 1;
        rdat0 = '0;
        rdat1 = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);

        tick(3);
        chk("R11 u0 req in reset", int'(req[0]), 0);
        chk("R11 u1 req in reset", int'(req[1]), 0);
        chk("R11 u0 valid in reset", int'(vld[0]), 0);
        chk("R11 u1 valid in reset", int'(vld[1]), 0);

        // R1 / R2: fill with the decoder stalled
        rst_n = 1'b1;
        do_flush(20'h10);
        tick(30);
        chk("R1 u0 fetch count", log0.size(), 3);
        chk("R1 u0 last fetch", int'(log0[2]), 'h14);
        chk("R1 u0 idle when full", int'(req[0]), 0);
        chk("R2 u1 fetch count", log1.size(), 4);
        chk("R2 u1 last fetch", int'(log1[3]), 'h13);
        chk("R9 u0 valid when filled", int'(vld[0]), 1);

        // R10: overwrite a byte already held in both queues
        mem[8'h12] = ~mem[8'h12];

        // R3 / R4: one byte taken
        ready = 1'b1;
        tick(1);
        ready = 1'b0;
        tick(8);
        chk("R3 u0 no fetch with one free", log0.size(), 3);
        chk("R4 u1 refetch with one free", log1.size(), 5);
        chk("R4 u1 refetch address", int'(log1[4]), 'h14);

        // R3: second byte taken gives room for a word
        ready = 1'b1;
        tick(1);
        ready = 1'b0;
        tick(8);
        chk("R3 u0 fetch with two free", log0.size(), 4);
        chk("R3 u0 fetch address", int'(log0[3]), 'h16);
        chk("R4 u1 fetch count", log1.size(), 6);

        // R9 / R10: stream out in order
        ready = 1'b1;
        tick(40);
        ready = 1'b0;
        tick(20);

        // R5: odd start on the two-byte path
        b0 = log0.size();
        b1 = log1.size();
        do_flush(20'h21);
        tick(30);
        chk("R5 u0 first fetch odd", int'(log0[b0]), 'h21);
        chk("R5 u0 second fetch aligned", int'(log0[b0 + 1]), 'h22);
        chk("R5 u0 third fetch", int'(log0[b0 + 2]), 'h24);
        chk("R5 u0 fetch count", log0.size() - b0, 3);
        chk("R2 u1 fetch count odd start", log1.size() - b1, 4);
        chk("R2 u1 last fetch odd start", int'(log1[b1 + 3]), 'h24);
        ready = 1'b1;
        tick(20);
        ready = 1'b0;
        tick(20);

        // R6 / R8: second flush while a slow fetch is outstanding
        lat = 6;
        b0 = log0.size();
        b1 = log1.size();
        do_flush(20'h40);
        chk("R6 u0 valid after flush", int'(vld[0]), 0);
        chk("R6 u1 valid after flush", int'(vld[1]), 0);
        tick(2);
        chk("R7 u0 request outstanding", int'(req[0]), 1);
        do_flush(20'h80);
        ready = 1'b1;
        tick(60);
        ready = 1'b0;
        chk("R8 u0 stale fetch", int'(log0[b0]), 'h40);
        chk("R6 u0 fetch after flush", int'(log0[b0 + 1]), 'h80);
        chk("R8 u1 stale fetch", int'(log1[b1]), 'h40);
        chk("R6 u1 fetch after flush", int'(log1[b1 + 1]), 'h80);
        tick(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule